// File: doc/BRIEF.md
# Receive Link Performance Monitor Counters

This block keeps five 16-bit event counters for one receive link of a T1/E1 framer. An upstream framer supplies per-event strobes and two alignment status flags. The strobes cover received framing bits or frame alignment words, non-alignment-frame bit 2, per-submultiframe CRC-4 check results, received E bits and Sa6 nibbles. The flags report loss of frame alignment and loss of CRC-4 multiframe alignment. Each counter applies its own qualification and its own inhibit rule before it counts an event.

Software reads a counter through a small synchronous port with a read strobe, an address and a registered data output. A read returns the count as it stood in the strobe cycle and clears that counter in the same cycle. An event that lands in the cycle of the read is kept, not dropped. The counters stop at their maximum value and do not wrap.

Top module: `lnk_perfmon`

## Requirements
- R1: After reset every counter holds 0, so a read of any address 0 to 4 returns 0x0000.
- R2: A read with `rd_en` high and `rd_addr` in 0..4 puts that counter's value from the strobe cycle on `rd_data` one clock later and clears the counter in the same cycle. `rd_data` holds its value while `rd_en` is low. The address map is 0 frame error, 1 CRC error, 2 E-bit, 3 Sa6 code 001x, 4 Sa6 code 00x1.
- R3: A counter at 0xFFFF stays at 0xFFFF when more events arrive. It never wraps to a smaller value, except when it is read.
- R4: Events that arrive in the cycle of a clearing read of the same counter are counted after the clear, so the counter then holds the number of those events.
- R5: The CRC counter adds 1 on each `crc_strobe` with `crc_err` high, but not while `mf_lost` is high.
- R6: The E-bit counter adds 1 on each `ebit_strobe` with `ebit_val` low, but not while `mf_lost` is high.
- R7: On each `smf_strobe` the block evaluates `sa6_nibble`, where bit 3 is the first bit received. Counter 3 adds 1 when bits 3:1 equal 001. Counter 4 adds 1 when bits 3:2 equal 00 and bit 0 equals 1. Code 0011 counts in both. No nibble is counted without the strobe or while `mf_lost` is high.
- R8: With `cfg_e1_mode` low, the frame error counter adds 1 on each `fbit_strobe` with `fbit_err` high, but not while `frame_lost` is high. In this mode the alignment-word and bit-2 inputs have no effect.
- R9: With `cfg_e1_mode` high, each `fas_strobe` whose `fas_word` differs from 7'b0011011 adds exactly 1 to the frame error counter, however many bits are wrong. Nothing is counted while `frame_lost` is high.
- R10: With `cfg_e1_mode` and `cfg_nfas_chk` both high, each `nfas_strobe` with `nfas_bit2` low adds 1 to the frame error counter. With `cfg_nfas_chk` low these events are ignored.
- R11: A read of address 5, 6 or 7 returns 0x0000 and clears no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_e1_mode | input | 1 | 1 = E1 frame error rules, 0 = DS1 rules |
| cfg_nfas_chk | input | 1 | Enables checking of non-alignment-frame bit 2 in E1 mode |
| frame_lost | input | 1 | Frame alignment lost |
| mf_lost | input | 1 | CRC-4 multiframe alignment lost |
| fbit_strobe | input | 1 | DS1 framing bit received |
| fbit_err | input | 1 | That framing bit was wrong |
| fas_strobe | input | 1 | E1 frame alignment word received |
| fas_word | input | 7 | Received alignment word |
| nfas_strobe | input | 1 | E1 non-alignment frame received |
| nfas_bit2 | input | 1 | Received bit 2 of that frame |
| crc_strobe | input | 1 | Submultiframe CRC-4 check done |
| crc_err | input | 1 | That check failed |
| ebit_strobe | input | 1 | E bit received |
| ebit_val | input | 1 | Received E bit value |
| smf_strobe | input | 1 | Submultiframe boundary, Sa6 nibble valid |
| sa6_nibble | input | 4 | Sa6 bits of the submultiframe, bit 3 first |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Counter address |
| rd_data | output | 16 | Registered read data |

## Verification
Every count is held in internal state, so a wrong count shows up at the ports only on the next read of that counter. A read reveals the value one clock after its strobe. The bench therefore reads each counter right after each stimulus pattern. It also compares `rd_data` with a behavioural model on every clock, which catches a counter that is wrong for any earlier reason at its first read. Clear-on-read faults show up one read later, as a non-zero second read or as a lost coincident event. A saturation fault shows up only after more than 65535 events, so the bench drives that many.

// File: rtl/lnk_perfmon_pkg.sv
package lnk_perfmon_pkg;

   localparam int NUM_CNT = 5;
   localparam int INC_W   = 2;

   typedef enum logic [2:0] {
      CSEL_FRAME = 3'd0,
      CSEL_CRC   = 3'd1,
      CSEL_EBIT  = 3'd2,
      CSEL_SA6A  = 3'd3,
      CSEL_SA6B  = 3'd4
   } cnt_sel_e;

   typedef struct packed {
      logic e1_mode;
      logic nfas_chk;
   } pm_cfg_t;

endpackage

// File: rtl/lnk_pm_evt_qual.sv
module lnk_pm_evt_qual
   import lnk_perfmon_pkg::*;
#(
   parameter int               FAS_W       = 7,
   parameter logic [FAS_W-1:0] FAS_PATTERN = 7'b0011011,
   parameter logic [3:0]       SA6A_VAL    = 4'b0010,
   parameter logic [3:0]       SA6A_MASK   = 4'b1110,
   parameter logic [3:0]       SA6B_VAL    = 4'b0001,
   parameter logic [3:0]       SA6B_MASK   = 4'b1101
) (
   input  pm_cfg_t                        cfg,
   input  logic                           frame_lost,
   input  logic                           mf_lost,
   input  logic                           fbit_strobe,
   input  logic                           fbit_err,
   input  logic                           fas_strobe,
   input  logic [FAS_W-1:0]               fas_word,
   input  logic                           nfas_strobe,
   input  logic                           nfas_bit2,
   input  logic                           crc_strobe,
   input  logic                           crc_err,
   input  logic                           ebit_strobe,
   input  logic                           ebit_val,
   input  logic                           smf_strobe,
   input  logic [3:0]                     sa6_nibble,
   output logic [NUM_CNT-1:0][INC_W-1:0]  inc
);

   logic             fas_bad;
   logic             nfas_bad;
   logic [INC_W-1:0] frame_inc;
   logic [1:0]       sa6_hit;

   // One error per bad alignment word, whatever the number of bad bits
   always_comb begin
      fas_bad  = fas_strobe && (fas_word != FAS_PATTERN);
      nfas_bad = cfg.nfas_chk && nfas_strobe && !nfas_bit2;
      if (cfg.e1_mode) begin
         frame_inc = INC_W'(fas_bad) + INC_W'(nfas_bad);
      end else begin
         frame_inc = INC_W'(fbit_strobe && fbit_err);
      end
      if (frame_lost) begin
         frame_inc = '0;
      end
   end

   for (genvar gi = 0; gi < 2; gi++) begin : g_sa6
      localparam logic [3:0] MVAL  = (gi == 0) ? SA6A_VAL  : SA6B_VAL;
      localparam logic [3:0] MMASK = (gi == 0) ? SA6A_MASK : SA6B_MASK;
      assign sa6_hit[gi] = smf_strobe && !mf_lost &&
                           ((sa6_nibble & MMASK) == (MVAL & MMASK));
   end

   always_comb begin
      inc             = '0;
      inc[CSEL_FRAME] = frame_inc;
      inc[CSEL_CRC]   = INC_W'(crc_strobe && crc_err && !mf_lost);
      inc[CSEL_EBIT]  = INC_W'(ebit_strobe && !ebit_val && !mf_lost);
      inc[CSEL_SA6A]  = INC_W'(sa6_hit[0]);
      inc[CSEL_SA6B]  = INC_W'(sa6_hit[1]);
   end

endmodule

// File: rtl/lnk_pm_satcnt.sv
module lnk_pm_satcnt #(
   parameter int CNT_W    = 16,
   parameter int INC_W    = 2,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [INC_W-1:0] inc,
   output logic [CNT_W-1:0] q
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] base;
   logic [CNT_W:0]   sum;
   logic [CNT_W-1:0] nxt;

   // A clearing read restarts from zero, so events of the same cycle survive
   assign base = clr ? '0 : q;
   assign sum  = {1'b0, base} + (CNT_W+1)'(inc);

   if (SATURATE) begin : g_sat
      assign nxt = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
   end else begin : g_wrap
      logic unused_carry;
      assign unused_carry = sum[CNT_W];
      assign nxt          = sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= nxt;
      end
   end

endmodule

// File: rtl/lnk_pm_rdport.sv
module lnk_pm_rdport
   import lnk_perfmon_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           rd_en,
   input  logic [ADDR_W-1:0]              rd_addr,
   input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt,
   output logic [NUM_CNT-1:0]             clr,
   output logic [CNT_W-1:0]               rd_data
);

   logic [CNT_W-1:0] sel_val;

   for (genvar gk = 0; gk < NUM_CNT; gk++) begin : g_clr
      assign clr[gk] = rd_en && (rd_addr == ADDR_W'(gk));
   end

   always_comb begin
      sel_val = '0;
      for (int k = 0; k < NUM_CNT; k++) begin
         if (clr[k]) begin
            sel_val = cnt[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= sel_val;
      end
   end

endmodule

// File: rtl/lnk_perfmon.sv
module lnk_perfmon
   import lnk_perfmon_pkg::*;
#(
   parameter int               CNT_W       = 16,
   parameter int               ADDR_W      = 3,
   parameter int               FAS_W       = 7,
   parameter logic [FAS_W-1:0] FAS_PATTERN = 7'b0011011,
   parameter bit               SATURATE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_e1_mode,
   input  logic              cfg_nfas_chk,
   input  logic              frame_lost,
   input  logic              mf_lost,
   input  logic              fbit_strobe,
   input  logic              fbit_err,
   input  logic              fas_strobe,
   input  logic [FAS_W-1:0]  fas_word,
   input  logic              nfas_strobe,
   input  logic              nfas_bit2,
   input  logic              crc_strobe,
   input  logic              crc_err,
   input  logic              ebit_strobe,
   input  logic              ebit_val,
   input  logic              smf_strobe,
   input  logic [3:0]        sa6_nibble,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data
);

   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("lnk_perfmon: CNT_W must be at least 2");
   end
   if ((1 << ADDR_W) < NUM_CNT) begin : g_bad_addr_w
      $error("lnk_perfmon: ADDR_W too narrow for the counter bank");
   end
   if (FAS_W < 1) begin : g_bad_fas_w
      $error("lnk_perfmon: FAS_W must be positive");
   end

   pm_cfg_t                       cfg;
   logic [NUM_CNT-1:0][INC_W-1:0] evt_inc;
   logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
   logic [NUM_CNT-1:0]            cnt_clr;

   assign cfg.e1_mode  = cfg_e1_mode;
   assign cfg.nfas_chk = cfg_nfas_chk;

   lnk_pm_evt_qual #(
      .FAS_W       (FAS_W),
      .FAS_PATTERN (FAS_PATTERN)
   ) i_qual (
      .cfg         (cfg),
      .frame_lost  (frame_lost),
      .mf_lost     (mf_lost),
      .fbit_strobe (fbit_strobe),
      .fbit_err    (fbit_err),
      .fas_strobe  (fas_strobe),
      .fas_word    (fas_word),
      .nfas_strobe (nfas_strobe),
      .nfas_bit2   (nfas_bit2),
      .crc_strobe  (crc_strobe),
      .crc_err     (crc_err),
      .ebit_strobe (ebit_strobe),
      .ebit_val    (ebit_val),
      .smf_strobe  (smf_strobe),
      .sa6_nibble  (sa6_nibble),
      .inc         (evt_inc)
   );

   for (genvar gc = 0; gc < NUM_CNT; gc++) begin : g_cnt
      lnk_pm_satcnt #(
         .CNT_W    (CNT_W),
         .INC_W    (INC_W),
         .SATURATE (SATURATE)
      ) i_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (cnt_clr[gc]),
         .inc   (evt_inc[gc]),
         .q     (cnt_q[gc])
      );
   end

   lnk_pm_rdport #(
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W)
   ) i_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .cnt     (cnt_q),
      .clr     (cnt_clr),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/lnk_perfmon_chk.sv
module lnk_perfmon_chk
   import lnk_perfmon_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int ADDR_W   = 3,
   parameter bit SATURATE = 1'b1
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          rd_en,
   input logic [ADDR_W-1:0]             rd_addr,
   input logic [CNT_W-1:0]              rd_data,
   input logic                          frame_lost,
   input logic                          mf_lost,
   input logic [NUM_CNT-1:0][INC_W-1:0] evt_inc,
   input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_CNT - 1);
   localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

   // R2: registered read data of a mapped address
   p_read_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr <= LAST_ADDR) |=> rd_data == $past(cnt_q[rd_addr]));

   // R2: read data holds between reads
   p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R11: unmapped addresses read as zero
   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr > LAST_ADDR) |=> rd_data == '0);

   for (genvar gk = 0; gk < NUM_CNT; gk++) begin : g_per_cnt
      // R4: after a clearing read only the same-cycle events remain
      p_clear_keeps_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && rd_addr == ADDR_W'(gk)) |=>
            cnt_q[gk] == CNT_W'($past(evt_inc[gk])));

      if (SATURATE) begin : g_sat_chk
         // R3: no wrap while not read
         p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_en && rd_addr == ADDR_W'(gk)) |=> cnt_q[gk] >= $past(cnt_q[gk]));
         // R3: full counter stays full
         p_hold_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[gk] == CNT_MAX && !(rd_en && rd_addr == ADDR_W'(gk))) |=>
               cnt_q[gk] == CNT_MAX);
      end

      if (gk == 0) begin : g_frame_inh
         // R8/R9: frame error counter frozen while frame alignment is lost
         p_frame_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_lost && !(rd_en && rd_addr == ADDR_W'(gk))) |=> $stable(cnt_q[gk]));
      end else begin : g_mf_inh
         // R5/R6/R7: multiframe-qualified counters frozen while multiframe lost
         p_mf_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mf_lost && !(rd_en && rd_addr == ADDR_W'(gk))) |=> $stable(cnt_q[gk]));
      end
   end

endmodule

bind lnk_perfmon lnk_perfmon_chk #(
   .CNT_W    (CNT_W),
   .ADDR_W   (ADDR_W),
   .SATURATE (SATURATE)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_en      (rd_en),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .frame_lost (frame_lost),
   .mf_lost    (mf_lost),
   .evt_inc    (evt_inc),
   .cnt_q      (cnt_q)
);

// File: tb/test_lnk_perfmon.sv
`timescale 1ns/1ps
module test_lnk_perfmon;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_e1_mode = 1'b0, cfg_nfas_chk = 1'b0;
   logic        frame_lost = 1'b0, mf_lost = 1'b0;
   logic        fbit_strobe = 1'b0, fbit_err = 1'b0;
   logic        fas_strobe = 1'b0;
   logic [6:0]  fas_word = 7'b0011011;
   logic        nfas_strobe = 1'b0, nfas_bit2 = 1'b1;
   logic        crc_strobe = 1'b0, crc_err = 1'b0;
   logic        ebit_strobe = 1'b0, ebit_val = 1'b1;
   logic        smf_strobe = 1'b0;
   logic [3:0]  sa6_nibble = 4'b0000;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_addr = 3'd0;
   logic [15:0] rd_data;

   int    n_vec = 0;
   int    n_bad = 0;
   string phase = "R1";

   always #10 clk = ~clk;

   lnk_perfmon i_lnk_perfmon (
      .clk(clk), .rst_n(rst_n), .cfg_e1_mode(cfg_e1_mode), .cfg_nfas_chk(cfg_nfas_chk),
      .frame_lost(frame_lost), .mf_lost(mf_lost), .fbit_strobe(fbit_strobe),
      .fbit_err(fbit_err), .fas_strobe(fas_strobe), .fas_word(fas_word),
      .nfas_strobe(nfas_strobe), .nfas_bit2(nfas_bit2), .crc_strobe(crc_strobe),
      .crc_err(crc_err), .ebit_strobe(ebit_strobe), .ebit_val(ebit_val),
      .smf_strobe(smf_strobe), .sa6_nibble(sa6_nibble), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // Behavioural reference model
   int m_cnt [5];
   int m_rd = 0;

   always @(posedge clk) begin
      int ev [5];
      if (!rst_n) begin
         foreach (m_cnt[i]) m_cnt[i] = 0;
         m_rd = 0;
      end else begin
         foreach (ev[i]) ev[i] = 0;
         if (!frame_lost) begin
            if (cfg_e1_mode) begin
               if (fas_strobe && fas_word != 7'b0011011) ev[0]++;
               if (cfg_nfas_chk && nfas_strobe && nfas_bit2 == 1'b0) ev[0]++;
            end else if (fbit_strobe && fbit_err) begin
               ev[0]++;
            end
         end
         if (!mf_lost) begin
            if (crc_strobe && crc_err) ev[1]++;
            if (ebit_strobe && ebit_val == 1'b0) ev[2]++;
            if (smf_strobe && sa6_nibble[3:1] == 3'b001) ev[3]++;
            if (smf_strobe && sa6_nibble[3:2] == 2'b00 && sa6_nibble[0]) ev[4]++;
         end
         if (rd_en) m_rd = (rd_addr < 5) ? m_cnt[rd_addr] : 0;
         foreach (m_cnt[i]) begin
            if (rd_en && rd_addr == i) m_cnt[i] = ev[i];
            else m_cnt[i] = (m_cnt[i] + ev[i] > 65535) ? 65535 : m_cnt[i] + ev[i];
         end
      end
   end

   // Every-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         n_vec++;
         if (rd_data !== 16'(m_rd)) begin
            n_bad++;
            $display("FAIL %s model compare: rd_data=%h expected=%h", phase, rd_data, 16'(m_rd));
         end
      end
   end

   task automatic check_read(input logic [2:0] a, input int expv, input string req);
      rd_en   = 1'b1;
      rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      n_vec++;
      if (rd_data !== 16'(expv)) begin
         n_bad++;
         $display("FAIL %s read addr %0d: actual=%h expected=%h", req, a, rd_data, 16'(expv));
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic quiet();
      fbit_strobe = 0; fas_strobe = 0; nfas_strobe = 0; crc_strobe = 0;
      ebit_strobe = 0; smf_strobe = 0;
   endtask

   task automatic crc_ev(input logic e, input logic lost);
      crc_strobe = 1; crc_err = e; mf_lost = lost; tick(1); quiet(); mf_lost = 0;
   endtask

   task automatic ebit_ev(input logic v, input logic lost);
      ebit_strobe = 1; ebit_val = v; mf_lost = lost; tick(1); quiet(); mf_lost = 0;
   endtask

   task automatic sa6_ev(input logic [3:0] nib, input logic stb, input logic lost);
      smf_strobe = stb; sa6_nibble = nib; mf_lost = lost; tick(1); quiet(); mf_lost = 0;
   endtask

   task automatic fbit_ev(input logic e, input logic lost);
      fbit_strobe = 1; fbit_err = e; frame_lost = lost; tick(1); quiet(); frame_lost = 0;
   endtask

   task automatic fas_ev(input logic [6:0] w, input logic lost);
      fas_strobe = 1; fas_word = w; frame_lost = lost; tick(1); quiet(); frame_lost = 0;
   endtask

   task automatic nfas_ev(input logic b2);
      nfas_strobe = 1; nfas_bit2 = b2; tick(1); quiet();
   endtask

   // Watchdog
   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1: reset state
      phase = "R1";
      for (int a = 0; a < 5; a++) check_read(3'(a), 0, "R1");

      // R5: CRC errors with multiframe inhibit
      phase = "R5";
      crc_ev(1, 0); crc_ev(0, 0); crc_ev(1, 0); crc_ev(0, 0); crc_ev(1, 0);
      crc_ev(1, 1); crc_ev(1, 1);
      check_read(3'd1, 3, "R5");
      // R2: cleared by the read
      phase = "R2";
      check_read(3'd1, 0, "R2");
      tick(2);
      n_vec++;
      if (rd_data !== 16'h0000) begin
         n_bad++;
         $display("FAIL R2 hold: actual=%h expected=%h", rd_data, 16'h0000);
      end

      // R6: E bits
      phase = "R6";
      ebit_ev(0, 0); ebit_ev(1, 0); ebit_ev(0, 0); ebit_ev(0, 0); ebit_ev(1, 0);
      ebit_ev(0, 0); ebit_ev(0, 1);
      check_read(3'd2, 4, "R6");

      // R7: Sa6 code matching
      phase = "R7";
      sa6_ev(4'b0010, 1, 0); sa6_ev(4'b0011, 1, 0); sa6_ev(4'b0001, 1, 0);
      sa6_ev(4'b0100, 1, 0); sa6_ev(4'b1011, 1, 0); sa6_ev(4'b0011, 0, 0);
      sa6_ev(4'b0010, 1, 1); sa6_ev(4'b0001, 1, 1);
      check_read(3'd3, 2, "R7");
      check_read(3'd4, 2, "R7");

      // R8: DS1 framing bits
      phase = "R8";
      cfg_e1_mode = 0;
      fbit_ev(1, 0); fbit_ev(1, 0); fbit_ev(0, 0); fbit_ev(1, 0);
      fbit_ev(1, 1); fbit_ev(1, 1);
      fas_ev(7'b1111111, 0); cfg_nfas_chk = 1; nfas_ev(0); cfg_nfas_chk = 0;
      check_read(3'd0, 3, "R8");

      // R9: E1 alignment words, one per bad word
      phase = "R9";
      cfg_e1_mode = 1;
      fas_ev(7'b0011011, 0); fas_ev(7'b0011010, 0); fas_ev(7'b1100100, 0);
      fas_ev(7'b0111011, 0); fas_ev(7'b0000000, 1);
      fbit_ev(1, 0);
      check_read(3'd0, 3, "R9");

      // R10: non-alignment bit 2 option
      phase = "R10";
      cfg_nfas_chk = 0;
      nfas_ev(0); nfas_ev(0);
      check_read(3'd0, 0, "R10");
      cfg_nfas_chk = 1;
      nfas_ev(0); nfas_ev(1); nfas_ev(0);
      fas_strobe = 1; fas_word = 7'b0001011; nfas_strobe = 1; nfas_bit2 = 0;
      tick(1); quiet();
      check_read(3'd0, 4, "R10");
      cfg_nfas_chk = 0;

      // R4: coincident event during a clearing read
      phase = "R4";
      repeat (5) crc_ev(1, 0);
      crc_strobe = 1; crc_err = 1;
      check_read(3'd1, 5, "R4");
      quiet();
      check_read(3'd1, 1, "R4");

      // R11: unmapped address
      phase = "R11";
      fas_ev(7'b0000000, 0); fas_ev(7'b0000000, 0);
      check_read(3'd6, 0, "R11");
      check_read(3'd5, 0, "R11");
      check_read(3'd7, 0, "R11");
      check_read(3'd0, 2, "R11");

      // R3: saturation
      phase = "R3";
      crc_strobe = 1; crc_err = 1;
      tick(65540);
      quiet();
      check_read(3'd1, 65535, "R3");
      check_read(3'd1, 0, "R3");

      tick(2);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule